// File: doc/BRIEF.md
# Subcode Channel Serial Output

This block turns the per-frame subcode symbol of a disc playback datapath into a serial stream that a host reads at its own pace. Once per disc frame it receives an 8-bit symbol that holds the P, Q, R, S, T, U, V and W channel bits. With the symbol comes a marker that flags the two sync symbols opening each 98-frame block. On each arrival the block raises a frame strobe and puts the P bit on the data pin. The host then clocks the remaining seven bits out with a read clock of its own.

The host read clock is asynchronous to the system clock. It is synchronised with a flop chain and edge-detected, and each rising edge advances the stream by one bit. A block flag follows the symbol marker, so it stays high across the two sync-symbol frames. Suppose the host is too slow and the next symbol arrives before all eight bits have been read. The unread bits are then discarded, the shifter reloads, and an overrun flag marks that frame. The serial output shares pins with a text output path, so an enable input is provided. While the enable is low, every output is low and all state is cleared.

Top module: `subcode_serial_out`

## Requirements
- R1: After reset, frame_sync_o, block_sync_o, pw_o and overrun_o are all 0.
- R2: A symbol accepted on a clock edge (sym_valid_i high, enable_i high) drives frame_sync_o high for exactly FS_LEN cycles (default 4), starting with the cycle after that edge.
- R3: In the cycle after acceptance, pw_o shows the P bit, which is sym_i[7]. The channel bits follow in the order P, Q, R, S, T, U, V, W, taken from sym_i[7] down to sym_i[0].
- R4: Each rising edge of rd_clk_i advances pw_o to the next bit within SYNC_STAGES+1 system clock edges (3 by default). Falling edges and a steady rd_clk_i do not advance the stream.
- R5: The rising edge after the one that exposed W clears pw_o to 0. pw_o stays 0, through any further read clock edges, until the next symbol is accepted.
- R6: block_sync_o takes the value of sym_sync_i when a symbol is accepted and holds it until the next accepted symbol.
- R7: If a symbol is accepted while unread bits remain, the unread bits are dropped and the new P bit is presented. overrun_o is set to 1 and held until the next accepted symbol. An accepted symbol that finds all eight bits read clears overrun_o to 0.
- R8: While enable_i is low, all outputs are 0 and symbols and read clock edges are ignored. After enable_i returns high, pw_o, frame_sync_o and overrun_o stay 0 until a new symbol is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Subcode output enable (low when the text path owns the pins) |
| sym_valid_i | input | 1 | One-cycle strobe: a new frame symbol is present |
| sym_i | input | SYM_W | Subcode symbol, bit 7 = P down to bit 0 = W |
| sym_sync_i | input | 1 | Symbol is one of the two block sync symbols |
| rd_clk_i | input | 1 | Host read clock, asynchronous |
| frame_sync_o | output | 1 | Frame strobe, FS_LEN cycles per symbol |
| block_sync_o | output | 1 | High during block sync symbol frames |
| pw_o | output | 1 | Serial channel bit |
| overrun_o | output | 1 | Previous symbol was not fully read |

## Verification
The shifter is driven with 0xA5, 0x3C and 0x01. The alternating pattern exposes an order reversal or a skipped shift. The run-of-ones pattern separates a one-edge slip from correct timing. The single W bit shows that the last bit is presented and then cleared. The host clock is also driven with falling-only transitions and with extra rising edges after W, which separates true edge detection from level sampling. A second symbol is sent partway through a read and again after a full read, so the overrun flag is seen both set and cleared. A burst with the enable low checks that the block accepts neither symbols nor edges while disabled.

// File: rtl/subq_pkg.sv
package subq_pkg;
  localparam int unsigned SBQ_SYM_W   = 8;
  localparam int unsigned SBQ_FS_LEN  = 4;
  localparam int unsigned SBQ_SYNC_ST = 2;
endpackage

// File: rtl/sbq_edge_sync.sv
module sbq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  AST_ONE_PULSE_PER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R4
endmodule

// File: rtl/sbq_frame_sync.sv
module sbq_frame_sync #(
  parameter int unsigned FS_LEN = 4,
  localparam int unsigned CW = $clog2(FS_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic load_i,
  input  logic mark_i,
  output logic fs_o,
  output logic blk_o
);
  logic [CW-1:0] cnt_q;
  logic          blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= CW'(FS_LEN);
      blk_q <= mark_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fs_o  = (cnt_q != '0);
  assign blk_o = blk_q;

  AST_FS_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_i) |=> fs_o); // R2
  AST_BLK_FOLLOWS_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_i) |=> (blk_o == $past(mark_i))); // R6
  AST_BLK_CLR_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !blk_o && !fs_o); // R8
endmodule

// File: rtl/sbq_shifter.sv
module sbq_shifter #(
  parameter int unsigned SYM_W = 8,
  localparam int unsigned CW = $clog2(SYM_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             rise_i,
  output logic             bit_o,
  output logic             ovr_o
);
  logic [SYM_W-1:0] sh_q;
  logic [CW-1:0]    left_q;
  logic             ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      ovr_q  <= 1'b0;
    end else if (!en_i) begin
      sh_q   <= '0;
      left_q <= '0;
      ovr_q  <= 1'b0;
    end else if (load_i) begin
      sh_q   <= sym_i;
      left_q <= CW'(SYM_W);
      ovr_q  <= (left_q != '0);
    end else if (rise_i && left_q != '0) begin
      sh_q   <= {sh_q[SYM_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign bit_o = sh_q[SYM_W-1];
  assign ovr_o = ovr_q;

  AST_LEFT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= CW'(SYM_W)); // R4
  AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && rise_i && left_q != '0) |=> (left_q == $past(left_q) - 1'b1)); // R4
  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q == '0) |-> !bit_o); // R5
  AST_OVR_ON_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_i && left_q != '0) |=> ovr_o); // R7
  AST_DIS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (left_q == '0) && !ovr_o); // R8
endmodule

// File: rtl/subcode_serial_out.sv
module subcode_serial_out
  import subq_pkg::*;
#(
  parameter int unsigned SYM_W       = SBQ_SYM_W,
  parameter int unsigned FS_LEN      = SBQ_FS_LEN,
  parameter int unsigned SYNC_STAGES = SBQ_SYNC_ST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             sym_valid_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             sym_sync_i,
  input  logic             rd_clk_i,
  output logic             frame_sync_o,
  output logic             block_sync_o,
  output logic             pw_o,
  output logic             overrun_o
);
  logic load, rise, fs, blk, bit_s, ovr;

  assign load = sym_valid_i & enable_i;

  sbq_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .async_i(rd_clk_i), .rise_o(rise)
  );

  sbq_frame_sync #(.FS_LEN(FS_LEN)) i_frame (
    .clk_i, .rst_ni, .en_i(enable_i), .load_i(load), .mark_i(sym_sync_i),
    .fs_o(fs), .blk_o(blk)
  );

  sbq_shifter #(.SYM_W(SYM_W)) i_shift (
    .clk_i, .rst_ni, .en_i(enable_i), .load_i(load), .sym_i(sym_i),
    .rise_i(rise), .bit_o(bit_s), .ovr_o(ovr)
  );

  // hold pins low the same cycle the enable drops
  assign frame_sync_o = fs    & enable_i;
  assign block_sync_o = blk   & enable_i;
  assign pw_o         = bit_s & enable_i;
  assign overrun_o    = ovr   & enable_i;

  AST_DIS_PINS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !frame_sync_o && !block_sync_o && !pw_o && !overrun_o); // R8
endmodule

// File: tb/test_subcode_serial_out.sv
module test_subcode_serial_out;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic       vld = 1'b0;
  logic [7:0] sym = '0;
  logic       mark = 1'b0;
  logic       rdc = 1'b0;
  logic       fs, bs, pw, ovr;
  int         total = 0;
  int         bad = 0;

  always #2.5 clk = ~clk;

  subcode_serial_out i_subcode_serial_out (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .sym_valid_i(vld), .sym_i(sym),
    .sym_sync_i(mark), .rd_clk_i(rdc), .frame_sync_o(fs), .block_sync_o(bs),
    .pw_o(pw), .overrun_o(ovr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] s, input logic m);
    @(negedge clk);
    vld = 1'b1; sym = s; mark = m;
    @(negedge clk);
    vld = 1'b0; mark = 1'b0;
  endtask

  task automatic rd_rise();
    rdc = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_fall();
    rdc = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check(fs == 0 && bs == 0 && pw == 0 && ovr == 0, "R1", {fs, bs, pw, ovr}, 0);
  endtask

  // full read of one symbol, checks every bit and the tail
  task automatic t_read(input logic [7:0] s, input string tag);
    send(s, 1'b0);
    check(pw == s[7], {"R3 P bit ", tag}, pw, s[7]);
    for (int i = 6; i >= 0; i--) begin
      rd_rise();
      check(pw == s[i], {"R4 bit ", tag}, pw, s[i]);
      rd_fall();
      check(pw == s[i], {"R4 fall no shift ", tag}, pw, s[i]);
    end
    rd_rise();
    check(pw == 0, {"R5 after W ", tag}, pw, 0);
    rd_fall();
  endtask

  task automatic t_frame_sync();
    int hi = 0;
    send(8'h00, 1'b0);
    for (int i = 0; i < 8; i++) begin
      if (fs) hi++;
      @(negedge clk);
    end
    check(hi == 4, "R2 strobe length", hi, 4);
  endtask

  task automatic t_tail();
    t_read(8'h01, "0x01");
    rd_rise(); rd_fall(); rd_rise();
    check(pw == 0, "R5 extra edges", pw, 0);
    rd_fall();
  endtask

  task automatic t_block();
    send(8'h80, 1'b1);
    check(bs == 1, "R6 S0", bs, 1);
    repeat (6) @(negedge clk);
    check(bs == 1, "R6 hold", bs, 1);
    send(8'h80, 1'b1);
    check(bs == 1, "R6 S1", bs, 1);
    send(8'h80, 1'b0);
    check(bs == 0, "R6 data frame", bs, 0);
  endtask

  task automatic t_overrun();
    for (int k = 0; k < 8; k++) begin rd_rise(); rd_fall(); end
    send(8'hF0, 1'b0);
    check(ovr == 0, "R7 clean load", ovr, 0);
    rd_rise(); rd_fall(); rd_rise(); rd_fall();
    send(8'h2A, 1'b0);
    check(ovr == 1, "R7 overrun set", ovr, 1);
    check(pw == 0, "R7 new P bit", pw, 0);
    rd_rise();
    check(pw == 0, "R7 new Q bit", pw, 0);
    rd_fall(); rd_rise();
    check(pw == 1, "R7 new R bit", pw, 1);
    rd_fall();
    for (int k = 0; k < 6; k++) begin rd_rise(); rd_fall(); end
    send(8'h00, 1'b0);
    check(ovr == 0, "R7 overrun cleared", ovr, 0);
    for (int k = 0; k < 8; k++) begin rd_rise(); rd_fall(); end
  endtask

  task automatic t_disable();
    send(8'hFF, 1'b1);
    @(negedge clk);
    en = 1'b0;
    #0.5;
    check(pw == 0 && bs == 0 && fs == 0, "R8 pins low", {fs, bs, pw}, 0);
    repeat (2) @(negedge clk);
    send(8'hFF, 1'b1);
    rd_rise(); rd_fall();
    check(pw == 0 && fs == 0 && bs == 0 && ovr == 0, "R8 ignored", {fs, bs, pw, ovr}, 0);
    en = 1'b1;
    repeat (2) @(negedge clk);
    check(pw == 0 && fs == 0 && ovr == 0, "R8 nothing pending", {fs, pw, ovr}, 0);
    send(8'h80, 1'b0);
    check(pw == 1 && ovr == 0, "R8 resumes", {pw, ovr}, 2);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame_sync();
        t_read(8'hA5, "0xA5");
        t_read(8'h3C, "0x3C");
        t_tail();
        t_block();
        t_overrun();
        t_disable();
      end
      begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule